// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block is the exception-entry logic of a system-control coprocessor for a 32-bit RISC core. Each cycle it accepts up to three requests: a debug breakpoint, a non-maskable/reset request, and a normal exception with a cause code. Qualifiers arrive with the requests: a TLB-refill flag, an interrupt level, the faulting instruction address and a branch-delay-slot flag. It picks one request and updates the control registers for that exception level. It then emits a one-cycle redirect carrying the handler address, together with a pulse that clears the load-linked reservation.

Each of the three exception levels has its own return-address register and its own delay-slot flag. For normal exceptions, the handler offset depends on the exception-level bit, on TLB refill and on whether the cause is an interrupt. The bootstrap bit in Status selects the vector base. Software reads and writes the six control registers through a small port addressed by register number.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, Status reads 0x00400004 (bootstrap bit 22 = 1, error-level bit 2 = 1, exception-level bit 1 = 0), Cause, Debug and the three return registers read 0, and no redirect or reservation-clear pulse is present.
- R2: A normal exception writes its 5-bit code into Cause bits 6:2. If Status bit 1 was clear, it also loads EPC with the faulting address, or that address minus 4 when the delay-slot flag is set. It then sets Cause bit 31 to the delay-slot flag and sets Status bit 1.
- R3: A normal exception taken while Status bit 1 is already set leaves EPC and Cause bit 31 unchanged.
- R4: A normal exception's handler address is a base plus an offset. The base is 0xBFC00200 when Status bit 22 is 1 and 0x80000000 when it is 0. The offset is 0x180 when Status bit 1 is set. Otherwise it is 0x000 for a refill on codes 2 or 3, 0x200 for code 0 (interrupt), and 0x180 for any other code.
- R5: For code 0, interrupt level 1 sets Cause bit 11 and level 2 sets Cause bit 15. Any other level sets no bit and raises the level-error output for one cycle.
- R6: A non-maskable/reset request writes 1 into Cause bits 18:16 and loads ErrorEPC with the address, or the address minus 4 in a delay slot. It sets Cause bit 30 to the delay-slot flag, sets Status bit 2, and redirects to 0xBFC00000.
- R7: When Debug bit 30 is clear, a debug breakpoint loads DEPC with the address, or the address minus 4 in a delay slot. It sets Debug bit 31 to the delay-slot flag, sets Debug bits 30 and 1, and redirects to 0xBFC00200.
- R8: A debug breakpoint arriving while Debug bit 30 is set has no effect: no redirect, no pulse, and no register change.
- R9: Requests arriving in the same cycle are served in the order debug, then non-maskable, then normal. Exactly one is taken and the others are discarded.
- R10: Each taken entry produces, one clock after the request, a one-cycle redirect with the handler address and a one-cycle reservation-clear pulse.
- R11: The software port addresses registers by number: Status 12, Cause 13, EPC 14, Debug 23, DEPC 24, ErrorEPC 30. Any other number reads 0. Cause bits 6:2, 11 and 15 ignore software writes.
- R12: When an exception is taken in the same cycle as a software write, the software write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_req_i | input | 1 | Debug breakpoint request |
| nmi_req_i | input | 1 | Non-maskable/reset request |
| exc_req_i | input | 1 | Normal exception request |
| exc_code_i | input | 5 | Normal exception cause code |
| refill_i | input | 1 | TLB refill qualifier |
| int_level_i | input | 2 | Interrupt level for code 0 |
| fault_pc_i | input | 32 | Faulting instruction address |
| in_slot_i | input | 1 | Fault lies in a branch delay slot |
| sw_we_i | input | 1 | Software write strobe |
| sw_addr_i | input | 5 | Software register number |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Software read data (combinational) |
| redirect_valid_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Handler address |
| llbit_clr_o | output | 1 | Load-linked reservation clear pulse |
| int_level_err_o | output | 1 | Unsupported interrupt level seen |

## Verification
The hardest states to reach from the ports are a normal exception with the exception-level bit already set, and a debug breakpoint arriving while debug mode is active. Both depend on register state that is normally left behind by earlier entries. The stimulus first writes Status, EPC and Debug through the software port to fixed values, then fires the request. This makes the vector table rows independent of one another, and also sets up the same-cycle collisions of all three requests and of an entry with a software write.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 32;
  localparam int CODE_W = 5;
  localparam int RNUM_W = 5;

  localparam logic [RNUM_W-1:0] RN_STATUS = 5'd12;
  localparam logic [RNUM_W-1:0] RN_CAUSE  = 5'd13;
  localparam logic [RNUM_W-1:0] RN_EPC    = 5'd14;
  localparam logic [RNUM_W-1:0] RN_DEBUG  = 5'd23;
  localparam logic [RNUM_W-1:0] RN_DEPC   = 5'd24;
  localparam logic [RNUM_W-1:0] RN_ERREPC = 5'd30;

  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_BEV = 22;

  localparam int CA_CODE_LO = 2;
  localparam int CA_IP3 = 11;
  localparam int CA_IP7 = 15;
  localparam int CA_EXC2_LO = 16;
  localparam int CA_BD2 = 30;
  localparam int CA_BD = 31;

  localparam int DB_DBP = 1;
  localparam int DB_DM = 30;
  localparam int DB_DBD = 31;

  localparam logic [CODE_W-1:0] CODE_INT  = 5'd0;
  localparam logic [CODE_W-1:0] CODE_TLBL = 5'd2;
  localparam logic [CODE_W-1:0] CODE_TLBS = 5'd3;

  localparam logic [XLEN-1:0] OFF_REFILL  = 32'h0000_0000;
  localparam logic [XLEN-1:0] OFF_GENERAL = 32'h0000_0180;
  localparam logic [XLEN-1:0] OFF_INTR    = 32'h0000_0200;

  localparam logic [XLEN-1:0] STATUS_RST = (32'd1 << ST_BEV) | (32'd1 << ST_ERL);
  localparam logic [XLEN-1:0] CAUSE_RO   = (32'h1F << CA_CODE_LO) | (32'd1 << CA_IP3) | (32'd1 << CA_IP7);

  typedef enum logic [1:0] {SRC_NONE, SRC_DBG, SRC_NMI, SRC_NORM} exc_src_e;

  function automatic logic [XLEN-1:0] pick_offset(input logic exl, input logic [CODE_W-1:0] code,
                                                  input logic refill);
    if (exl) return OFF_GENERAL;
    if (refill && (code == CODE_TLBL || code == CODE_TLBS)) return OFF_REFILL;
    if (code == CODE_INT) return OFF_INTR;
    return OFF_GENERAL;
  endfunction

  function automatic logic [XLEN-1:0] return_addr(input logic [XLEN-1:0] pc, input logic slot);
    return slot ? pc - 32'd4 : pc;
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_req,
  input  logic nmi_req,
  input  logic norm_req,
  input  logic dm_active,
  output logic take_dbg,
  output logic take_nmi,
  output logic take_norm
);
  logic dbg_ok;

  always_comb begin
    dbg_ok    = dbg_req && !dm_active;
    take_dbg  = dbg_ok;
    take_nmi  = nmi_req && !dbg_ok;
    take_norm = norm_req && !dbg_ok && !nmi_req;
  end

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_dbg, take_nmi, take_norm}));
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] DBG_VEC   = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] NMI_VEC   = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] BASE_BOOT = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] BASE_RUN  = 32'h8000_0000
) (
  input  logic              take_dbg,
  input  logic              take_nmi,
  input  logic              bev,
  input  logic              exl,
  input  logic [CODE_W-1:0] code,
  input  logic              refill,
  output logic [XLEN-1:0]   target
);
  logic [XLEN-1:0] base;

  always_comb begin
    base = bev ? BASE_BOOT : BASE_RUN;
    if (take_dbg)      target = DBG_VEC;
    else if (take_nmi) target = NMI_VEC;
    else               target = base + pick_offset(exl, code, refill);
  end
endmodule

// File: rtl/exc_cp0_file.sv
module exc_cp0_file
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_dbg,
  input  logic              take_nmi,
  input  logic              take_norm,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        int_level,
  input  logic [XLEN-1:0]   fault_pc,
  input  logic              in_slot,
  input  logic              sw_we,
  input  logic [RNUM_W-1:0] sw_addr,
  input  logic [XLEN-1:0]   sw_wdata,
  output logic [XLEN-1:0]   sw_rdata,
  output logic              bev,
  output logic              exl,
  output logic              dm_active,
  output logic              level_bad
);
  logic [XLEN-1:0] status_q, cause_q, epc_q, errepc_q, debug_q, depc_q;
  logic [XLEN-1:0] ret_pc;
  logic            take_any, sw_ok, is_int;

  always_comb begin
    ret_pc    = return_addr(fault_pc, in_slot);
    take_any  = take_dbg || take_nmi || take_norm;
    sw_ok     = sw_we && !take_any;
    is_int    = take_norm && (code == CODE_INT);
    level_bad = is_int && (int_level != 2'd1) && (int_level != 2'd2);
    bev       = status_q[ST_BEV];
    exl       = status_q[ST_EXL];
    dm_active = debug_q[DB_DM];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
      cause_q  <= '0;
      epc_q    <= '0;
      errepc_q <= '0;
      debug_q  <= '0;
      depc_q   <= '0;
    end else if (take_dbg) begin
      depc_q          <= ret_pc;
      debug_q[DB_DBD] <= in_slot;
      debug_q[DB_DM]  <= 1'b1;
      debug_q[DB_DBP] <= 1'b1;
    end else if (take_nmi) begin
      errepc_q                          <= ret_pc;
      cause_q[CA_EXC2_LO+2:CA_EXC2_LO]  <= 3'd1;
      cause_q[CA_BD2]                   <= in_slot;
      status_q[ST_ERL]                  <= 1'b1;
    end else if (take_norm) begin
      cause_q[CA_CODE_LO+CODE_W-1:CA_CODE_LO] <= code;
      if (!status_q[ST_EXL]) begin
        epc_q            <= ret_pc;
        cause_q[CA_BD]   <= in_slot;
        status_q[ST_EXL] <= 1'b1;
      end
      if (is_int && int_level == 2'd1) cause_q[CA_IP3] <= 1'b1;
      if (is_int && int_level == 2'd2) cause_q[CA_IP7] <= 1'b1;
    end else if (sw_ok) begin
      case (sw_addr)
        RN_STATUS: status_q <= sw_wdata;
        RN_CAUSE:  cause_q  <= (cause_q & CAUSE_RO) | (sw_wdata & ~CAUSE_RO);
        RN_EPC:    epc_q    <= sw_wdata;
        RN_DEBUG:  debug_q  <= sw_wdata;
        RN_DEPC:   depc_q   <= sw_wdata;
        RN_ERREPC: errepc_q <= sw_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sw_addr)
      RN_STATUS: sw_rdata = status_q;
      RN_CAUSE:  sw_rdata = cause_q;
      RN_EPC:    sw_rdata = epc_q;
      RN_DEBUG:  sw_rdata = debug_q;
      RN_DEPC:   sw_rdata = depc_q;
      RN_ERREPC: sw_rdata = errepc_q;
      default:   sw_rdata = '0;
    endcase
  end

  assert_exl_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_norm |=> status_q[ST_EXL]);
  assert_epc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_norm && status_q[ST_EXL]) |=> $stable(epc_q));
  assert_erl_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> status_q[ST_ERL]);
  assert_dm_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_dbg |=> (debug_q[DB_DM] && debug_q[DB_DBP]));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_req_i,
  input  logic              nmi_req_i,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              refill_i,
  input  logic [1:0]        int_level_i,
  input  logic [XLEN-1:0]   fault_pc_i,
  input  logic              in_slot_i,
  input  logic              sw_we_i,
  input  logic [RNUM_W-1:0] sw_addr_i,
  input  logic [XLEN-1:0]   sw_wdata_i,
  output logic [XLEN-1:0]   sw_rdata_o,
  output logic              redirect_valid_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              llbit_clr_o,
  output logic              int_level_err_o
);
  logic            take_dbg, take_nmi, take_norm, take_any;
  logic            bev, exl, dm_active, level_bad;
  logic [XLEN-1:0] target;

  exc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n),
    .dbg_req(dbg_req_i), .nmi_req(nmi_req_i), .norm_req(exc_req_i),
    .dm_active(dm_active),
    .take_dbg(take_dbg), .take_nmi(take_nmi), .take_norm(take_norm)
  );

  exc_vector_gen u_vec (
    .take_dbg(take_dbg), .take_nmi(take_nmi), .bev(bev), .exl(exl),
    .code(exc_code_i), .refill(refill_i), .target(target)
  );

  exc_cp0_file u_regs (
    .clk(clk), .rst_n(rst_n),
    .take_dbg(take_dbg), .take_nmi(take_nmi), .take_norm(take_norm),
    .code(exc_code_i), .int_level(int_level_i), .fault_pc(fault_pc_i),
    .in_slot(in_slot_i), .sw_we(sw_we_i), .sw_addr(sw_addr_i),
    .sw_wdata(sw_wdata_i), .sw_rdata(sw_rdata_o),
    .bev(bev), .exl(exl), .dm_active(dm_active), .level_bad(level_bad)
  );

  assign take_any = take_dbg || take_nmi || take_norm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
      llbit_clr_o      <= 1'b0;
      int_level_err_o  <= 1'b0;
    end else begin
      redirect_valid_o <= take_any;
      redirect_pc_o    <= take_any ? target : '0;
      llbit_clr_o      <= take_any;
      int_level_err_o  <= level_bad;
    end
  end

  assert_vec_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> (redirect_pc_o[6:0] == 7'd0));
  assert_dm_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_i && dm_active && !nmi_req_i && !exc_req_i) |=> !redirect_valid_o);
  assert_llclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> llbit_clr_o);
endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_req_i = 0, nmi_req_i = 0, exc_req_i = 0;
  logic [4:0]  exc_code_i = 0;
  logic        refill_i = 0;
  logic [1:0]  int_level_i = 0;
  logic [31:0] fault_pc_i = 0;
  logic        in_slot_i = 0;
  logic        sw_we_i = 0;
  logic [4:0]  sw_addr_i = 0;
  logic [31:0] sw_wdata_i = 0;
  logic [31:0] sw_rdata_o, redirect_pc_o;
  logic        redirect_valid_o, llbit_clr_o, int_level_err_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] v, prior;

  always #2.5 clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .dbg_req_i(dbg_req_i), .nmi_req_i(nmi_req_i),
    .exc_req_i(exc_req_i), .exc_code_i(exc_code_i), .refill_i(refill_i),
    .int_level_i(int_level_i), .fault_pc_i(fault_pc_i), .in_slot_i(in_slot_i),
    .sw_we_i(sw_we_i), .sw_addr_i(sw_addr_i), .sw_wdata_i(sw_wdata_i),
    .sw_rdata_o(sw_rdata_o), .redirect_valid_o(redirect_valid_o),
    .redirect_pc_o(redirect_pc_o), .llbit_clr_o(llbit_clr_o),
    .int_level_err_o(int_level_err_o)
  );

  // row: {bev, exl, code[4:0], refill, slot, level[1:0], pc[31:0]}
  localparam logic [42:0] TBL [8] = '{
    {1'b1, 1'b0, 5'd2, 1'b1, 1'b0, 2'd0, 32'h0040_0100},
    {1'b0, 1'b0, 5'd2, 1'b1, 1'b0, 2'd0, 32'h0040_0200},
    {1'b0, 1'b0, 5'd3, 1'b0, 1'b1, 2'd0, 32'h0040_0300},
    {1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 2'd1, 32'h0040_0400},
    {1'b1, 1'b0, 5'd0, 1'b0, 1'b1, 2'd2, 32'h0040_0500},
    {1'b0, 1'b1, 5'd2, 1'b1, 1'b1, 2'd0, 32'h0040_0600},
    {1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 2'd1, 32'h0040_0700},
    {1'b0, 1'b0, 5'd8, 1'b1, 1'b1, 2'd0, 32'h0040_0800}
  };

  function automatic logic [31:0] expect_vec(input logic bev, input logic exl,
                                             input logic [4:0] code, input logic rf);
    logic [31:0] off;
    off = 32'h180;
    if (!exl && code == 5'd0) off = 32'h200;
    if (!exl && rf && (code == 5'd2 || code == 5'd3)) off = 32'h0;
    return (bev ? 32'hBFC0_0200 : 32'h8000_0000) + off;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    sw_addr_i = a;
    #0.5;
    d = sw_rdata_o;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    sw_we_i = 1; sw_addr_i = a; sw_wdata_i = d;
    @(negedge clk);
    sw_we_i = 0;
  endtask

  task automatic fire(input logic d, input logic n, input logic e, input logic [4:0] code,
                      input logic rf, input logic [1:0] lvl, input logic [31:0] pc,
                      input logic slot);
    @(negedge clk);
    dbg_req_i = d; nmi_req_i = n; exc_req_i = e; exc_code_i = code;
    refill_i = rf; int_level_i = lvl; fault_pc_i = pc; in_slot_i = slot;
    @(negedge clk);
    dbg_req_i = 0; nmi_req_i = 0; exc_req_i = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(5'd12, v); chk("R1 status", v, 32'h0040_0004);
    rd(5'd13, v); chk("R1 cause", v, 32'h0);
    rd(5'd23, v); chk("R1 debug", v, 32'h0);
    rd(5'd14, v); chk("R1 epc", v, 32'h0);
    chk("R1 redirect", {30'd0, redirect_valid_o, llbit_clr_o}, 32'h0);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      logic bev, exl, rf, slot;
      logic [4:0] code;
      logic [1:0] lvl;
      logic [31:0] pc, exp_epc;
      {bev, exl, code, rf, slot, lvl, pc} = TBL[i];
      wr(5'd12, ({31'd0, bev} << 22) | ({31'd0, exl} << 1));
      wr(5'd14, 32'h1111_0000);
      wr(5'd13, 32'h0);
      fire(0, 0, 1, code, rf, lvl, pc, slot);
      chk("R4 vector", redirect_pc_o, expect_vec(bev, exl, code, rf));
      chk("R10 pulse", {31'd0, redirect_valid_o}, 32'd1);
      exp_epc = exl ? 32'h1111_0000 : (slot ? pc - 32'd4 : pc);
      rd(5'd14, v); chk(exl ? "R3 epc hold" : "R2 epc", v, exp_epc);
      rd(5'd13, v);
      chk("R2 code", {27'd0, v[6:2]}, {27'd0, code});
      chk(exl ? "R3 bd hold" : "R2 bd", {31'd0, v[31]}, {31'd0, exl ? 1'b0 : slot});
      if (code == 5'd0 && lvl == 2'd1) chk("R5 ip3", {31'd0, v[11]}, 32'd1);
      if (code == 5'd0 && lvl == 2'd2) chk("R5 ip7", {31'd0, v[15]}, 32'd1);
      rd(5'd12, v); chk("R2 exl", {31'd0, v[1]}, 32'd1);
    end

    // R10 pulse ends, reservation-clear accompanies entry
    fire(0, 0, 1, 5'd4, 0, 0, 32'h100, 0);
    chk("R10 llclr", {31'd0, llbit_clr_o}, 32'd1);
    @(negedge clk);
    chk("R10 one cycle", {30'd0, redirect_valid_o, llbit_clr_o}, 32'd0);

    // R5 bad level
    wr(5'd12, 32'h0);
    fire(0, 0, 1, 5'd0, 0, 2'd3, 32'h200, 0);
    chk("R5 level error", {31'd0, int_level_err_o}, 32'd1);

    // R6 nmi
    wr(5'd12, 32'h0);
    fire(0, 1, 0, 5'd0, 0, 0, 32'h0000_1000, 1);
    chk("R6 vector", redirect_pc_o, 32'hBFC0_0000);
    rd(5'd30, v); chk("R6 errorepc", v, 32'h0000_0FFC);
    rd(5'd13, v); chk("R6 bd2 exc2", {28'd0, v[30], v[18:16]}, 32'h9);
    rd(5'd12, v); chk("R6 erl", {31'd0, v[2]}, 32'd1);

    // R7 debug entry
    fire(1, 0, 0, 5'd0, 0, 0, 32'h0000_2000, 1);
    chk("R7 vector", redirect_pc_o, 32'hBFC0_0200);
    rd(5'd24, v); chk("R7 depc", v, 32'h0000_1FFC);
    rd(5'd23, v); chk("R7 debug", v, 32'hC000_0002);

    // R8 ignored while in debug mode
    fire(1, 0, 0, 5'd0, 0, 0, 32'h0000_2400, 0);
    chk("R8 no redirect", {30'd0, redirect_valid_o, llbit_clr_o}, 32'd0);
    rd(5'd24, v); chk("R8 depc kept", v, 32'h0000_1FFC);

    // R9 priority: debug wins
    wr(5'd23, 32'h0);
    fire(1, 1, 1, 5'd4, 0, 0, 32'h0000_3000, 0);
    chk("R9 debug first", redirect_pc_o, 32'hBFC0_0200);
    rd(5'd30, v); chk("R9 errorepc kept", v, 32'h0000_0FFC);
    // R9 nmi over normal while debug is masked
    wr(5'd14, 32'h7777_0000);
    wr(5'd12, 32'h0);
    fire(1, 1, 1, 5'd4, 0, 0, 32'h0000_4000, 0);
    chk("R9 nmi second", redirect_pc_o, 32'hBFC0_0000);
    rd(5'd30, v); chk("R9 errorepc", v, 32'h0000_4000);
    rd(5'd14, v); chk("R9 epc kept", v, 32'h7777_0000);

    // R11 read-only cause bits and unknown register
    rd(5'd13, prior);
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, v); chk("R11 cause ro", v, (prior & 32'h0000_887C) | 32'hFFFF_7783);
    rd(5'd5, v); chk("R11 unknown", v, 32'h0);

    // R12 collision
    wr(5'd12, 32'h0000_0002);
    wr(5'd14, 32'h5555_0000);
    @(negedge clk);
    exc_req_i = 1; exc_code_i = 5'd4; refill_i = 0; fault_pc_i = 32'h9000; in_slot_i = 0;
    sw_we_i = 1; sw_addr_i = 5'd14; sw_wdata_i = 32'hDEAD_0000;
    @(negedge clk);
    exc_req_i = 0; sw_we_i = 0;
    chk("R12 redirect", redirect_pc_o, 32'h8000_0180);
    rd(5'd14, v); chk("R12 write dropped", v, 32'h5555_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule